// File: doc/BRIEF.md
# Remap Control and Shape Slot Allocator

This block keeps the state that steers element-index remapping for a vector datapath. It holds five 2-bit selectors, one for each remappable operand (three sources, two destinations). It also holds a 5-bit enable field, four opaque shape descriptors and a 7-bit index-register base. A single-cycle setup command rewrites that state in one of two ways, chosen by a mode bit. In the bulk mode the state is wiped and every set mask bit gets the next free descriptor slot. In the targeted mode one selector is pointed at one named slot and nothing else changes.

A direct write port lets the same registers be loaded word by word. On the cycle of a setup command the direct write is dropped. The packed control word, the four descriptors and the index base are always visible on the outputs. A targeted command that names a selector which does not exist does nothing, and a flag is raised for one cycle.

Top module: `remap_ctrl_unit`

## Requirements
- R1: After synchronous reset, `ctrl_o`, every descriptor in `shape_o`, `idx_base_o` and `illegal_o` read zero.
- R2: Selector k (0..4 = source a, source b, source c, destination a, destination b) is at `ctrl_o[2k+1:2k]`. Its enable bit is `ctrl_o[10+k]`. Bits 31:15 always read zero.
- R3: A bulk command (`cmd_mm`=0) first clears all four descriptors and the control word, then sets the enable field equal to `cmd_mask`. A zero mask therefore leaves everything zero.
- R4: In a bulk command, set mask bits are taken from bit 0 upward, and the n-th set bit (n from 0) gets slot n mod 4. Its selector is set to that slot, and that slot's descriptor is loaded with `cmd_payload`. Example: mask 0b00110 gives control word 0x1810.
- R5: A bulk command with all five mask bits set points selectors 0 and 4 both at slot 0 and selectors 1..3 at slots 1..3. The control word is 0x7CE4.
- R6: A targeted command (`cmd_mm`=1) with `cmd_mask[2:0]` < 5 sets selector `cmd_mask[2:0]` to slot `cmd_mask[4:3]` and sets its enable bit. It loads that slot with `cmd_payload`. All other selectors, enables and descriptors keep their values. Example: mask 0b10011 from a cleared state gives control word 0x2080.
- R7: A targeted command with `cmd_mask[2:0]` of 5, 6 or 7 changes no state. `illegal_o` is high in the following cycle only.
- R8: Every command that takes effect loads `idx_base_o` with `{cmd_ireg, 2'b00}`.
- R9: A direct write with `wr_addr` 0..3 loads that descriptor slot. `wr_addr` 4 loads the control word from `wr_data[14:0]`. `wr_addr` 5..7 changes nothing.
- R10: When `cmd_valid` and `wr_en` are high in the same cycle, only the command acts. This holds even when the command is an illegal no-op.
- R11: With neither a command nor a direct write, all outputs hold and `illegal_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Setup command strobe |
| cmd_mm | input | 1 | 0 = bulk allocation, 1 = targeted update |
| cmd_mask | input | 5 | Operand mask (bulk) or {slot, selector index} (targeted) |
| cmd_ireg | input | 5 | Index register number, upper five bits |
| cmd_payload | input | SHAPE_W | Descriptor value to load |
| wr_en | input | 1 | Direct register write strobe |
| wr_addr | input | 3 | 0..3 descriptor slot, 4 control word |
| wr_data | input | SHAPE_W | Direct write data |
| ctrl_o | output | 32 | Packed control word |
| shape_o | output | 4*SHAPE_W | Descriptors, slot j at bits [j*SHAPE_W +: SHAPE_W] |
| idx_base_o | output | 7 | Expanded index register number |
| illegal_o | output | 1 | One-cycle flag after a targeted command with a bad selector |

## Verification
The bench sweeps all 32 masks in bulk mode from a dirty state. A design that skipped the initial clear would leave stale descriptors behind. Off-by-one ranking or a missing wrap to slot 0 would show up as wrong selectors at mask 0b11111. It then sweeps all 32 masks in targeted mode while state accumulates. A design that touched neighbouring selectors or slots, or acted on indices 5..7, would diverge from the running model. Collision cycles check that a direct write, even into a slot the command clears, is lost to the command.

// File: rtl/remap_ctrl_pkg.sv
package remap_ctrl_pkg;
  localparam int NUM_SEL    = 5;
  localparam int NUM_SLOTS  = 4;
  localparam int SLOT_W     = $clog2(NUM_SLOTS);
  localparam int MASK_W     = NUM_SEL;
  localparam int IDX_W      = 3;
  localparam int CTRL_W     = 32;
  localparam int EN_LSB     = 10;
  localparam int CTRL_USED  = EN_LSB + NUM_SEL;
  localparam int IREG_W     = 5;
  localparam int IREG_PAD   = 2;
  localparam int BASE_W     = IREG_W + IREG_PAD;
  localparam int WADDR_W    = 3;
  localparam int ADDR_CTRL  = NUM_SLOTS;

  typedef logic [SLOT_W-1:0] slot_t;

  typedef struct packed {
    logic [NUM_SEL-1:0]  en;
    slot_t [NUM_SEL-1:0] sel;
  } ctrl_t;

  function automatic logic [CTRL_W-1:0] pack_ctrl(ctrl_t c);
    logic [CTRL_W-1:0] w;
    w = '0;
    for (int k = 0; k < NUM_SEL; k++) w[k*SLOT_W +: SLOT_W] = c.sel[k];
    w[EN_LSB +: NUM_SEL] = c.en;
    return w;
  endfunction

  function automatic ctrl_t unpack_ctrl(logic [CTRL_USED-1:0] w);
    ctrl_t c;
    for (int k = 0; k < NUM_SEL; k++) c.sel[k] = w[k*SLOT_W +: SLOT_W];
    c.en = w[EN_LSB +: NUM_SEL];
    return c;
  endfunction
endpackage

// File: rtl/remap_alloc_seq.sv
module remap_alloc_seq
  import remap_ctrl_pkg::*;
(
  input  logic [MASK_W-1:0]    mask,
  output slot_t [NUM_SEL-1:0]  sel,
  output logic [NUM_SLOTS-1:0] slot_we
);
  // Rank of each set bit among the set bits below it, wrapped onto the slots.
  for (genvar k = 0; k < NUM_SEL; k++) begin : g_rank
    logic [MASK_W-1:0] below;
    assign below  = mask & MASK_W'((1 << k) - 1);
    assign sel[k] = mask[k] ? slot_t'($countones(below)) : slot_t'(0);
  end

  for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_we
    assign slot_we[j] = ($countones(mask) > j);
  end
endmodule

// File: rtl/remap_single_decode.sv
module remap_single_decode
  import remap_ctrl_pkg::*;
(
  input  logic [MASK_W-1:0]    mask,
  output slot_t                slot,
  output logic                 legal,
  output logic [NUM_SEL-1:0]   sel_hit,
  output logic [NUM_SLOTS-1:0] slot_we
);
  logic [IDX_W-1:0] idx;

  assign idx   = mask[IDX_W-1:0];
  assign slot  = mask[MASK_W-1:IDX_W];
  assign legal = (idx < IDX_W'(NUM_SEL));

  for (genvar k = 0; k < NUM_SEL; k++) begin : g_hit
    assign sel_hit[k] = legal && (idx == IDX_W'(k));
  end

  for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_we
    assign slot_we[j] = legal && (slot == SLOT_W'(j));
  end
endmodule

// File: rtl/remap_shape_bank.sv
module remap_shape_bank
  import remap_ctrl_pkg::*;
#(
  parameter int SHAPE_W = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           clear,
  input  logic [NUM_SLOTS-1:0]           cmd_we,
  input  logic [SHAPE_W-1:0]             cmd_data,
  input  logic [NUM_SLOTS-1:0]           dir_we,
  input  logic [SHAPE_W-1:0]             dir_data,
  output logic [NUM_SLOTS*SHAPE_W-1:0]   shapes
);
  for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_slot
    logic [SHAPE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)            q <= '0;
      else if (cmd_we[j]) q <= cmd_data;
      else if (clear)     q <= '0;
      else if (dir_we[j]) q <= dir_data;
    end
    assign shapes[j*SHAPE_W +: SHAPE_W] = q;
  end
endmodule

// File: rtl/remap_ctrl_unit.sv
module remap_ctrl_unit
  import remap_ctrl_pkg::*;
#(
  parameter int SHAPE_W = 32
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cmd_valid,
  input  logic                         cmd_mm,
  input  logic [4:0]                   cmd_mask,
  input  logic [4:0]                   cmd_ireg,
  input  logic [SHAPE_W-1:0]           cmd_payload,
  input  logic                         wr_en,
  input  logic [2:0]                   wr_addr,
  input  logic [SHAPE_W-1:0]           wr_data,
  output logic [31:0]                  ctrl_o,
  output logic [4*SHAPE_W-1:0]         shape_o,
  output logic [6:0]                   idx_base_o,
  output logic                         illegal_o
);
  slot_t [NUM_SEL-1:0]   a_sel;
  logic [NUM_SLOTS-1:0]  a_we;
  slot_t                 s_slot;
  logic                  s_legal;
  logic [NUM_SEL-1:0]    s_hit;
  logic [NUM_SLOTS-1:0]  s_we;

  remap_alloc_seq u_alloc (
    .mask    (cmd_mask),
    .sel     (a_sel),
    .slot_we (a_we)
  );

  remap_single_decode u_single (
    .mask    (cmd_mask),
    .slot    (s_slot),
    .legal   (s_legal),
    .sel_hit (s_hit),
    .slot_we (s_we)
  );

  logic cmd_bulk, cmd_tgt, cmd_take, dir_act, dir_ctrl;
  logic [NUM_SLOTS-1:0] bank_cmd_we, bank_dir_we;

  assign cmd_bulk = cmd_valid && !cmd_mm;
  assign cmd_tgt  = cmd_valid && cmd_mm;
  assign cmd_take = cmd_bulk || (cmd_tgt && s_legal);
  assign dir_act  = wr_en && !cmd_valid;
  assign dir_ctrl = dir_act && (wr_addr == WADDR_W'(ADDR_CTRL));

  for (genvar j = 0; j < NUM_SLOTS; j++) begin : g_dir
    assign bank_dir_we[j] = dir_act && (wr_addr == WADDR_W'(j));
  end

  assign bank_cmd_we = cmd_bulk ? a_we : (cmd_tgt ? s_we : '0);

  remap_shape_bank #(.SHAPE_W(SHAPE_W)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .clear    (cmd_bulk),
    .cmd_we   (bank_cmd_we),
    .cmd_data (cmd_payload),
    .dir_we   (bank_dir_we),
    .dir_data (wr_data),
    .shapes   (shape_o)
  );

  ctrl_t             ctrl_q, ctrl_d;
  logic [BASE_W-1:0] base_q;
  logic              ill_q;

  always_comb begin
    ctrl_d = ctrl_q;
    if (cmd_bulk) begin
      ctrl_d.en = cmd_mask;
      for (int k = 0; k < NUM_SEL; k++) ctrl_d.sel[k] = a_sel[k];
    end else if (cmd_tgt) begin
      for (int k = 0; k < NUM_SEL; k++) begin
        if (s_hit[k]) begin
          ctrl_d.sel[k] = s_slot;
          ctrl_d.en[k]  = 1'b1;
        end
      end
    end else if (dir_ctrl) begin
      ctrl_d = unpack_ctrl(wr_data[CTRL_USED-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      base_q <= '0;
      ill_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      ill_q  <= cmd_tgt && !s_legal;
      if (cmd_take) base_q <= {cmd_ireg, IREG_PAD'(0)};
    end
  end

  logic unused_rsv;
  assign unused_rsv = ^wr_data[SHAPE_W-1:CTRL_USED];

  assign ctrl_o     = pack_ctrl(ctrl_q);
  assign idx_base_o = base_q;
  assign illegal_o  = ill_q;
endmodule

// File: rtl/remap_ctrl_unit_chk.sv
module remap_ctrl_unit_chk
  import remap_ctrl_pkg::*;
#(
  parameter int SHAPE_W = 32
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 cmd_valid,
  input logic                 cmd_mm,
  input logic [4:0]           cmd_mask,
  input logic [4:0]           cmd_ireg,
  input logic                 wr_en,
  input logic [31:0]          ctrl_o,
  input logic [4*SHAPE_W-1:0] shape_o,
  input logic [6:0]           idx_base_o,
  input logic                 illegal_o
);
  logic [NUM_SEL-1:0] en_w;
  logic               bad_tgt, good_tgt;
  assign en_w     = ctrl_o[EN_LSB +: NUM_SEL];
  assign bad_tgt  = cmd_valid && cmd_mm && (cmd_mask[2:0] >= 3'd5);
  assign good_tgt = cmd_valid && cmd_mm && (cmd_mask[2:0] < 3'd5);

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (rst)
    ctrl_o[31:CTRL_USED] == '0);

  assert_bulk_enables_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_mm |=> en_w == $past(cmd_mask));

  assert_bulk_empty_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && !cmd_mm && cmd_mask == 5'd0 |=> ctrl_o == '0 && shape_o == '0);

  assert_tgt_enable_R6: assert property (@(posedge clk) disable iff (rst)
    good_tgt |=> en_w[$past(cmd_mask[2:0])]);

  assert_bad_noop_R7: assert property (@(posedge clk) disable iff (rst)
    bad_tgt |=> illegal_o && $stable(ctrl_o) && $stable(shape_o) && $stable(idx_base_o));

  assert_flag_cause_R7: assert property (@(posedge clk) disable iff (rst)
    !bad_tgt |=> !illegal_o);

  assert_base_load_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !bad_tgt) |=> idx_base_o[6:2] == $past(cmd_ireg));

  assert_cmd_wins_R10: assert property (@(posedge clk) disable iff (rst)
    bad_tgt && wr_en |=> $stable(ctrl_o) && $stable(shape_o));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid && !wr_en |=> $stable(ctrl_o) && $stable(shape_o) && $stable(idx_base_o));
endmodule

bind remap_ctrl_unit remap_ctrl_unit_chk #(.SHAPE_W(SHAPE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_mm     (cmd_mm),
  .cmd_mask   (cmd_mask),
  .cmd_ireg   (cmd_ireg),
  .wr_en      (wr_en),
  .ctrl_o     (ctrl_o),
  .shape_o    (shape_o),
  .idx_base_o (idx_base_o),
  .illegal_o  (illegal_o)
);

// File: tb/remap_ctrl_unit_tb.sv
module remap_ctrl_unit_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cmd_valid = 1'b0, cmd_mm = 1'b0;
  logic [4:0]   cmd_mask = '0, cmd_ireg = '0;
  logic [W-1:0] cmd_payload = '0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [31:0]  ctrl_o;
  logic [4*W-1:0] shape_o;
  logic [6:0]   idx_base_o;
  logic         illegal_o;

  remap_ctrl_unit #(.SHAPE_W(W)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_mm(cmd_mm),
    .cmd_mask(cmd_mask), .cmd_ireg(cmd_ireg), .cmd_payload(cmd_payload),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_o(ctrl_o), .shape_o(shape_o), .idx_base_o(idx_base_o),
    .illegal_o(illegal_o)
  );

  always #10 clk = ~clk;

  int checks = 0, failures = 0;
  bit done = 0;

  // expected-state model
  logic [1:0]   m_sel [5];
  logic [4:0]   m_en;
  logic [W-1:0] m_shape [4];
  logic [6:0]   m_base;
  logic         m_ill;

  function automatic logic [31:0] exp_ctrl();
    logic [31:0] w = '0;
    for (int k = 0; k < 5; k++) w[2*k +: 2] = m_sel[k];
    w[14:10] = m_en;
    return w;
  endfunction

  task automatic chk32(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    chk32(req, "ctrl", ctrl_o, exp_ctrl());
    for (int j = 0; j < 4; j++) chk32(req, $sformatf("shape%0d", j), shape_o[j*W +: W], m_shape[j]);
    chk32(req, "base", {25'd0, idx_base_o}, {25'd0, m_base});
    chk32(req, "illegal", {31'd0, illegal_o}, {31'd0, m_ill});
  endtask

  task automatic model_cmd(input logic mm, input logic [4:0] mask, input logic [4:0] ireg, input logic [W-1:0] pay);
    if (!mm) begin
      int n = 0;
      for (int j = 0; j < 4; j++) m_shape[j] = '0;
      for (int k = 0; k < 5; k++) m_sel[k] = 2'd0;
      m_en = mask;
      for (int k = 0; k < 5; k++) begin
        if (mask[k]) begin
          m_sel[k] = 2'(n % 4);
          m_shape[n % 4] = pay;
          n++;
        end
      end
      m_base = {ireg, 2'b00};
      m_ill = 1'b0;
    end else if (mask[2:0] < 3'd5) begin
      m_sel[mask[2:0]] = mask[4:3];
      m_en[mask[2:0]] = 1'b1;
      m_shape[mask[4:3]] = pay;
      m_base = {ireg, 2'b00};
      m_ill = 1'b0;
    end else begin
      m_ill = 1'b1;
    end
  endtask

  task automatic step(input logic v, input logic mm, input logic [4:0] mask, input logic [4:0] ireg,
                      input logic [W-1:0] pay, input logic we, input logic [2:0] addr, input logic [W-1:0] data);
    cmd_valid = v; cmd_mm = mm; cmd_mask = mask; cmd_ireg = ireg; cmd_payload = pay;
    wr_en = we; wr_addr = addr; wr_data = data;
    if (v) model_cmd(mm, mask, ireg, pay);
    else begin
      m_ill = 1'b0;
      if (we && addr < 3'd4) m_shape[addr[1:0]] = data;
      else if (we && addr == 3'd4) begin
        for (int k = 0; k < 5; k++) m_sel[k] = data[2*k +: 2];
        m_en = data[14:10];
      end
    end
    @(negedge clk);
    cmd_valid = 1'b0; wr_en = 1'b0;
  endtask

  task automatic dwrite(input logic [2:0] addr, input logic [W-1:0] data);
    step(1'b0, 1'b0, 5'd0, 5'd0, '0, 1'b1, addr, data);
  endtask

  task automatic cmd(input logic mm, input logic [4:0] mask, input logic [4:0] ireg, input logic [W-1:0] pay);
    step(1'b1, mm, mask, ireg, pay, 1'b0, 3'd0, '0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog run did not finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 5; k++) m_sel[k] = 2'd0;
    for (int j = 0; j < 4; j++) m_shape[j] = '0;
    m_en = '0; m_base = '0; m_ill = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check_all("R1");

    // direct writes (R9, R2)
    for (int j = 0; j < 4; j++) dwrite(3'(j), 32'h1111_0000 * 32'(j + 1) + 32'(j));
    check_all("R9");
    dwrite(3'd4, 32'hFFFF_FFFF);
    chk32("R2", "ctrl all-ones write", ctrl_o, 32'h0000_7FFF);
    check_all("R2");
    dwrite(3'd5, 32'hDEAD_BEEF);
    dwrite(3'd7, 32'h0BAD_F00D);
    check_all("R9");

    // idle hold (R11)
    step(1'b0, 1'b0, 5'd0, 5'd0, '0, 1'b0, 3'd0, '0);
    step(1'b0, 1'b0, 5'd0, 5'd0, '0, 1'b0, 3'd0, '0);
    check_all("R11");

    // bulk examples
    cmd(1'b0, 5'b00110, 5'd3, 32'hAAAA_0006);
    chk32("R4", "mask 00110", ctrl_o, 32'h0000_1810);
    check_all("R4");
    cmd(1'b0, 5'b10001, 5'd9, 32'hAAAA_0011);
    chk32("R4", "mask 10001", ctrl_o, 32'h0000_4400 | 32'h0000_0100);
    check_all("R8");
    cmd(1'b0, 5'b11111, 5'd31, 32'hAAAA_001F);
    chk32("R5", "mask 11111", ctrl_o, 32'h0000_7CE4);
    check_all("R5");

    // targeted example from cleared state
    cmd(1'b0, 5'b00000, 5'd0, 32'h0);
    check_all("R3");
    cmd(1'b1, 5'b10011, 5'd7, 32'hBBBB_0013);
    chk32("R6", "mask 10011", ctrl_o, 32'h0000_2080);
    check_all("R6");
    cmd(1'b1, 5'b11100, 5'd8, 32'hBBBB_001C);
    chk32("R6", "mask 11100", ctrl_o, 32'h0000_2080 | 32'h0000_4300);
    check_all("R6");

    // bulk sweep from a dirty state each time (R3, R4, R5)
    for (int m = 0; m < 32; m++) begin
      for (int j = 0; j < 4; j++) dwrite(3'(j), 32'hF0F0_0000 + 32'(m * 4 + j));
      dwrite(3'd4, 32'h0000_7FFF);
      cmd(1'b0, 5'(m), 5'(31 - m), 32'hC0DE_0000 + 32'(m));
      check_all(m == 31 ? "R5" : (m == 0 ? "R3" : "R4"));
    end

    // targeted sweep with accumulating state (R6, R7, R8)
    for (int j = 0; j < 4; j++) dwrite(3'(j), 32'h7700_0000 + 32'(j));
    dwrite(3'd4, 32'h0000_01B4);
    for (int m = 0; m < 32; m++) begin
      cmd(1'b1, 5'(m), 5'(m + 1), 32'h5A00_0000 + 32'(m << 4));
      check_all((m % 8) >= 5 ? "R7" : "R6");
      step(1'b0, 1'b0, 5'd0, 5'd0, '0, 1'b0, 3'd0, '0);
      check_all("R7");
    end

    // collisions: command beats direct write (R10)
    step(1'b1, 1'b0, 5'b00001, 5'd2, 32'h1234_5678, 1'b1, 3'd1, 32'hFFFF_0001);
    check_all("R10");
    step(1'b1, 1'b1, 5'b01010, 5'd4, 32'h8765_4321, 1'b1, 3'd4, 32'h0000_7FFF);
    check_all("R10");
    step(1'b1, 1'b1, 5'b00110, 5'd6, 32'h0, 1'b1, 3'd2, 32'hEEEE_EEEE);
    check_all("R10");
    step(1'b0, 1'b0, 5'd0, 5'd0, '0, 1'b0, 3'd0, '0);
    check_all("R11");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule